// File: doc/BRIEF.md
# Digit-Serial GF(2) Basis Converter

This block maps an M-bit binary field element from one basis representation to another. The mapping is a vector-by-matrix product over GF(2) with a fixed, dense M-by-M conversion matrix, which is supplied as a parameter and held in a small ROM. Each result bit is the XOR reduction of one matrix row ANDed with the input vector. The reverse mapping is a second instance of the same block, loaded with the inverse matrix.

A digit-width parameter D sets the trade between latency and area. When D is smaller than M, the converter fetches D rows per cycle and writes D result bits per cycle, so a conversion takes ceil(M/D) cycles. The final digit reads all-zero rows for row indices at or above M. When D is M or larger, the unit is a purely combinational path.

Operands enter and results leave on valid/ready streams. An input transfer happens on a rising edge where `in_valid` and `in_ready` are both high. An output transfer happens on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result is held unchanged, and no new operand is accepted until that result has been taken.

Top module: `basis_convert`

## Requirements
- R1: Result bit r equals the XOR reduction of (row r AND `in_vec`), where row r is `MATRIX[r*M +: M]` and bit c of a row multiplies `in_vec[c]`.
- R2: In the serial form (D < M), `out_valid` rises exactly ceil(M/D) clock edges after the edge that accepted the operand, and stays low before that.
- R3: In the serial form, `in_ready` is low from the accepting edge until the result has been transferred out. `in_vec` and `in_valid` have no effect on the result during that interval.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_vec` keeps its value.
- R5: The edge that transfers a result clears `out_valid` and raises `in_ready`.
- R6: When D does not divide M, the last digit still yields correct bits up to index M-1. The padding lanes read zero rows and do not disturb the result.
- R7: When D >= M, the block is combinational: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and `out_vec` is the product of the current `in_vec`.
- R8: While `rst_n` is low, and after it is released, `out_valid` is 0 and (serial form) `in_ready` is 1.
- R9: Converting a vector with a matrix, then converting the result with that matrix's inverse, returns the original vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Converter can take an operand |
| in_vec | input | M | Element in the source basis |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | M | Element in the target basis |

## Verification
The operand is accepted on edge k. The forward result is due on edge k+ceil(M/D), which is k+4 for M=7 and D=2. It passes to a chained inverse converter (D=3) on edge k+5. The round-tripped vector is due on edge k+8. The bench drives inputs and samples outputs on falling edges, and it counts each of these edges explicitly. It checks that valid is low at every earlier sample and high at the due sample. A held-output scenario stalls both stages and checks that the values stay stable at each falling edge. The combinational instance is checked one time step after its inputs change, with no clock involved.

// File: rtl/bconv_pkg.sv
package bconv_pkg;
  localparam int MAX_M = 32;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} conv_state_t;

  function automatic int num_digits(int m, int d);
    return (m + d - 1) / d;
  endfunction

  // Default matrix: row r has ones in columns 0..r (prefix parity map).
  function automatic logic [MAX_M*MAX_M-1:0] lower_tri(int m);
    logic [MAX_M*MAX_M-1:0] mat;
    mat = '0;
    for (int r = 0; r < m; r++)
      for (int c = 0; c <= r; c++)
        mat[r*m + c] = 1'b1;
    return mat;
  endfunction
endpackage

// File: rtl/bconv_rom.sv
module bconv_rom #(
  parameter int M = 7,
  parameter int DW = 2,
  parameter int IW = 2,
  parameter logic [M*M-1:0] MATRIX = '0
) (
  input  logic [IW-1:0]   digit_idx,
  output logic [DW*M-1:0] rows
);
  // One read returns DW consecutive rows; indices past M read as zero.
  always_comb begin
    int r;
    rows = '0;
    for (int j = 0; j < DW; j++) begin
      r = int'(digit_idx) * DW + j;
      if (r < M) rows[j*M +: M] = MATRIX[r*M +: M];
    end
  end
endmodule

// File: rtl/bconv_dot.sv
module bconv_dot #(
  parameter int M = 7,
  parameter int DW = 2
) (
  input  logic [DW*M-1:0] rows,
  input  logic [M-1:0]    vec,
  output logic [DW-1:0]   bits
);
  for (genvar j = 0; j < DW; j++) begin : g_lane
    assign bits[j] = ^(rows[j*M +: M] & vec);
  end
endmodule

// File: rtl/bconv_seq.sv
module bconv_seq
  import bconv_pkg::*;
#(
  parameter int M = 7,
  parameter int DW = 2,
  parameter int NDIG = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [M-1:0]  in_vec,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [M-1:0]  out_vec,
  output logic [IW-1:0] digit_idx,
  output logic [M-1:0]  held_vec,
  input  logic [DW-1:0] digit_bits
);
  localparam logic [IW-1:0] LAST = IW'(NDIG - 1);

  conv_state_t st;
  logic [IW-1:0] cnt;
  logic [M-1:0]  xreg;
  logic [M-1:0]  acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      xreg <= '0;
      acc  <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          xreg <= in_vec;
          cnt  <= '0;
          st   <= S_RUN;
        end
        S_RUN: begin
          for (int j = 0; j < DW; j++)
            if (int'(cnt) * DW + j < M) acc[int'(cnt) * DW + j] <= digit_bits[j];
          if (cnt == LAST) st <= S_HOLD;
          else cnt <= cnt + 1'b1;
        end
        S_HOLD: if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_HOLD);
  assign out_vec   = acc;
  assign digit_idx = cnt;
  assign held_vec  = xreg;

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid);
  a_r3_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |=> $stable(xreg));
  a_r2_digit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) && (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1) && !out_valid);
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec));
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
endmodule

// File: rtl/basis_convert.sv
module basis_convert #(
  parameter int M = 7,
  parameter int D = 2,
  parameter logic [M*M-1:0] MATRIX = (M*M)'(bconv_pkg::lower_tri(M))
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_vec,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_vec
);
  localparam int DW   = (D > M) ? M : D;
  localparam int NDIG = bconv_pkg::num_digits(M, DW);
  localparam int IW   = (NDIG > 1) ? $clog2(NDIG) : 1;

  logic [DW*M-1:0] rows;
  logic [DW-1:0]   bits;
  logic [IW-1:0]   digit_idx;
  logic [M-1:0]    dot_vec;

  bconv_rom #(.M(M), .DW(DW), .IW(IW), .MATRIX(MATRIX)) u_rom (
    .digit_idx(digit_idx),
    .rows(rows)
  );

  bconv_dot #(.M(M), .DW(DW)) u_dot (
    .rows(rows),
    .vec(dot_vec),
    .bits(bits)
  );

  if (NDIG == 1) begin : g_comb
    assign digit_idx = '0;
    assign dot_vec   = in_vec;
    assign out_vec   = bits;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end else begin : g_serial
    bconv_seq #(.M(M), .DW(DW), .NDIG(NDIG), .IW(IW)) u_seq (
      .clk(clk),
      .rst_n(rst_n),
      .in_valid(in_valid),
      .in_ready(in_ready),
      .in_vec(in_vec),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_vec(out_vec),
      .digit_idx(digit_idx),
      .held_vec(dot_vec),
      .digit_bits(bits)
    );
  end

  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/basis_convert_test.sv
module basis_convert_test;
  function automatic logic [48:0] fwd_mat();
    logic [48:0] m;
    m = '0;
    for (int r = 0; r < 7; r++)
      for (int c = 0; c <= r; c++) m[r*7 + c] = 1'b1;
    return m;
  endfunction

  function automatic logic [48:0] inv_mat();
    logic [48:0] m;
    m = '0;
    for (int r = 0; r < 7; r++) begin
      m[r*7 + r] = 1'b1;
      if (r > 0) m[r*7 + r - 1] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [48:0] FWD = fwd_mat();
  localparam logic [48:0] INV = inv_mat();
  localparam int NV = 8;
  localparam logic [6:0] VX [NV] = '{7'h00, 7'h01, 7'h40, 7'h02, 7'h7F, 7'h55, 7'h2A, 7'h18};
  localparam logic [6:0] VY [NV] = '{7'h00, 7'h7F, 7'h40, 7'h7E, 7'h55, 7'h33, 7'h66, 7'h08};

  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic uin_valid, uin_ready, uout_valid;
  logic [6:0] uin_vec, uout_vec;
  logic iout_valid, iin_ready, fin_ready;
  logic [6:0] iout_vec;
  logic w_in_valid, w_in_ready, w_out_valid, w_out_ready;
  logic [6:0] w_in_vec, w_out_vec;

  basis_convert #(.M(7), .D(2), .MATRIX(FWD)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(uin_valid), .in_ready(uin_ready),
    .in_vec(uin_vec), .out_valid(uout_valid), .out_ready(iin_ready), .out_vec(uout_vec));

  basis_convert #(.M(7), .D(3), .MATRIX(INV)) inv (
    .clk(clk), .rst_n(rst_n), .in_valid(uout_valid), .in_ready(iin_ready),
    .in_vec(uout_vec), .out_valid(iout_valid), .out_ready(fin_ready), .out_vec(iout_vec));

  basis_convert #(.M(7), .D(7), .MATRIX(FWD)) wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_in_valid), .in_ready(w_in_ready),
    .in_vec(w_in_vec), .out_valid(w_out_valid), .out_ready(w_out_ready), .out_vec(w_out_vec));

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Entered and left at a falling edge; operand accepted on the next rising edge k.
  task automatic run_vec(input logic [6:0] x, input logic [6:0] y);
    uin_valid = 1; uin_vec = x;
    check(uin_ready, "R5 idle ready", 32'(uin_ready), 1);
    @(negedge clk);
    uin_valid = 0; uin_vec = ~x;
    check(!uout_valid, "R2 early valid", 32'(uout_valid), 0);
    for (int n = 1; n < 4; n++) begin
      @(negedge clk);
      check(!uout_valid, "R2 early valid", 32'(uout_valid), 0);
    end
    @(negedge clk);
    check(uout_valid, "R2 valid due", 32'(uout_valid), 1);
    check(uout_vec == y, "R1 R6 forward result", 32'(uout_vec), 32'(y));
    @(negedge clk);
    check(!uout_valid && uin_ready, "R5 release", {uout_valid, uin_ready}, 2'b01);
    repeat (2) @(negedge clk);
    check(!iout_valid, "R2 inverse early", 32'(iout_valid), 0);
    @(negedge clk);
    check(iout_valid && iout_vec == x, "R9 round trip", 32'(iout_vec), 32'(x));
    @(negedge clk);
    check(!iout_valid, "R5 inverse release", 32'(iout_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    uin_valid = 0; uin_vec = '0; fin_ready = 1;
    w_in_valid = 0; w_in_vec = '0; w_out_ready = 0;
    repeat (3) @(negedge clk);
    check(!uout_valid && uin_ready && !iout_valid, "R8 in reset",
          {uout_valid, uin_ready, iout_valid}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    check(!uout_valid && uin_ready, "R8 after reset", {uout_valid, uin_ready}, 2'b01);

    for (int i = 0; i < NV; i++) run_vec(VX[i], VY[i]);

    // Back-pressure on the inverse stage, then on the forward stage.
    fin_ready = 0;
    uin_valid = 1; uin_vec = 7'h55;
    @(negedge clk);
    uin_valid = 0;
    repeat (8) @(negedge clk);
    check(iout_valid && iout_vec == 7'h55, "R9 stalled round trip", 32'(iout_vec), 32'h55);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check(iout_valid && iout_vec == 7'h55, "R4 inverse hold", 32'(iout_vec), 32'h55);
    end
    uin_valid = 1; uin_vec = 7'h2A;
    check(uin_ready, "R5 forward ready", 32'(uin_ready), 1);
    @(negedge clk);
    uin_valid = 0; uin_vec = 7'h11;
    repeat (4) @(negedge clk);
    uin_valid = 1;
    for (int n = 0; n < 3; n++) begin
      check(uout_valid && uout_vec == 7'h66, "R4 forward hold", 32'(uout_vec), 32'h66);
      check(!uin_ready, "R3 busy not ready", 32'(uin_ready), 0);
      @(negedge clk);
    end
    uin_valid = 0;
    fin_ready = 1;
    @(negedge clk);
    check(!iout_valid && uout_valid, "R5 inverse drained", {iout_valid, uout_valid}, 2'b01);
    @(negedge clk);
    check(!uout_valid, "R5 forward drained", 32'(uout_valid), 0);
    repeat (2) @(negedge clk);
    @(negedge clk);
    check(iout_valid && iout_vec == 7'h2A, "R3 R9 ignored input", 32'(iout_vec), 32'h2A);
    @(negedge clk);

    // Full-width combinational variant.
    for (int i = 0; i < NV; i++) begin
      w_in_valid = 1; w_in_vec = VX[i]; w_out_ready = i[0];
      #1;
      check(w_out_valid && w_in_ready == w_out_ready && w_out_vec == VY[i],
            "R7 combinational", 32'(w_out_vec), 32'(VY[i]));
    end
    w_in_valid = 0;
    #1;
    check(!w_out_valid, "R7 valid follows", 32'(w_out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule